// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes received Ethernet frames as a byte stream and stores them in a circular buffer kept in a local dual-port memory. The preamble has already been removed and the FCS is still present. The block writes each frame's bytes after a 4-byte gap. When the last byte has been accepted, it fills that gap with a 32-bit header word holding a 16-bit status and a 16-bit length. The host only trusts a frame once its header is present. Because the header is written last, the host never sees a partly stored frame as valid.

The block keeps the hardware write offset and compares it with a host read pointer to work out free space and a buffer-empty flag. The host programs its read pointer 16 bytes behind the offset it has actually consumed. A frame that does not fit is dropped, and a missed-frame counter records it. Interrupt-style status bits report good frames, errored frames, ring overflow and bytes lost while a header is being written. The host clears each status bit by writing a one to it.

A small set of configuration inputs controls the block. One selects the ring size. Another selects whether frame data wraps back to offset 0 or runs on past the ring end into spare memory.

Top module: `rx_ring_writer`

## Requirements
- R1: The ring size is 8192 bytes shifted left by `cfgSizeIdx` (0, 1, 2 give 8, 16, 32 KiB; the value 3 acts as 2). All offsets are taken modulo the ring size.
- R2: One cycle after the last byte of an accepted frame, the block writes the header as a single word at the frame's start offset with `memBe`=4'hF. `memData[15:0]` is the status and `memData[31:16]` is the byte count (FCS included). Status bits: bit0 = no error, bits5..1 = `rxErr[4:0]`, bits15..13 = `rxMatch[2:0]`, all other bits 0.
- R3: Byte i of a frame goes to byte offset start+4+i. It is written in the same cycle it arrives, at word address offset>>2, with a one-hot `memBe` bit offset[1:0] and the byte on every lane of `memData`.
- R4: After a header is written, `wrOffset` becomes (start + length + 7) with the low two bits cleared, modulo the ring size. `wrOffset` is therefore always 4-byte aligned.
- R5: The read offset is (`hostRdPtr` + 16) modulo the ring size. `bufEmpty` is 1 exactly when the read offset equals `wrOffset`.
- R6: With `cfgWrap`=0, data bytes whose offset passes the ring end continue at offset 0. With `cfgWrap`=1, they continue linearly past the end, and only `wrOffset` is folded.
- R7: Free space is (read − write) modulo the ring size, with 0 meaning the whole ring. Byte i is accepted only while i+8 < free space. The first byte refused sets `irqStat[4]` and increments the 24-bit `missedCnt`. The rest of that frame and its header are not written, and `wrOffset` is left unchanged.
- R8: A header write sets `irqStat[0]` when the frame had no error, or `irqStat[1]` when any `rxErr` bit was set.
- R9: A byte that arrives in the header-write cycle sets `irqStat[6]`. The frame it belongs to is discarded entirely, up to its last byte.
- R10: Writing 1 to an `irqClr` bit clears the matching `irqStat` bit. A set event in the same cycle wins over the clear.
- R11: After reset, `wrOffset`=0, `irqStat`=0, `missedCnt`=0 and `memWe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Byte valid |
| rxData | input | 8 | Frame byte |
| rxLast | input | 1 | Last byte of frame (with rxValid) |
| rxErr | input | 5 | Error flags, valid with the last byte |
| rxMatch | input | 3 | Address match class (bcast, phys, mcast), valid with the last byte |
| cfgSizeIdx | input | 2 | Ring size index |
| cfgWrap | input | 1 | 1: data runs linearly past the ring end |
| hostRdPtr | input | 16 | Host read pointer (consumed offset − 16) |
| irqClr | input | 8 | Write-one-to-clear strobes for irqStat |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 14 | Memory word address |
| memBe | output | 4 | Byte enables |
| memData | output | 32 | Write data |
| wrOffset | output | 16 | Hardware write offset |
| bufEmpty | output | 1 | No unread frame in the ring |
| irqStat | output | 8 | Status bits (0 ok, 1 error, 4 overflow, 6 lost byte) |
| missedCnt | output | 24 | Frames dropped for lack of room |

## Verification
Two collisions get the most attention. The first is a header commit in the same cycle as the first byte of the next frame. The bench drives that byte into the header cycle and then checks three things: the header still lands, bit 6 rises, and no byte of the late frame reaches memory. The second is a status set in the same cycle as a host clear. The bench pulses `irqClr` exactly in the header cycle, expects the bit being set to stay set, and expects an unrelated bit named in the same clear to drop.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef struct packed {
    logic wrByte;   // store the incoming byte
    logic wrHdr;    // store header word, advance offset
    logic cntClr;   // restart frame byte count
  } rxStrobe_t;
endpackage

// File: rtl/rx_ring_dp.sv
module rx_ring_dp
  import rx_ring_pkg::*;
#(
  parameter int BASE_BITS = 13,
  parameter int IDX_W     = 2,
  parameter int MAX_IDX   = 2,
  parameter int AW        = BASE_BITS + MAX_IDX + 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobe_t        strb,
  input  logic [IDX_W-1:0] cfgSizeIdx,
  input  logic             cfgWrap,
  input  logic [AW-1:0]    hostRdPtr,
  input  logic [7:0]       rxData,
  input  logic [15:0]      hdrStatus,
  output logic             roomOk,
  output logic [AW-1:0]    wrOffset,
  output logic             bufEmpty,
  output logic             memWe,
  output logic [AW-3:0]    memAddr,
  output logic [3:0]       memBe,
  output logic [31:0]      memData
);
  logic [IDX_W-1:0] idxEff;
  logic [AW:0]      ringSize;
  logic [AW-1:0]    mask, rdOff, gap, bytePos, dataPos, nextOff, cnt;
  logic [AW:0]      freeSpace;

  assign idxEff   = (cfgSizeIdx > IDX_W'(MAX_IDX)) ? IDX_W'(MAX_IDX) : cfgSizeIdx;
  assign ringSize = (AW+1)'(1) << (BASE_BITS + int'(idxEff));
  assign mask     = ringSize[AW-1:0] - 1'b1;

  // host pointer lags the consumed offset by 16
  assign rdOff     = (hostRdPtr + AW'(16)) & mask;
  assign gap       = (rdOff - wrOffset) & mask;
  assign freeSpace = (gap == '0) ? ringSize : {1'b0, gap};
  assign bufEmpty  = (gap == '0);
  // keep header plus alignment padding strictly short of the read offset
  assign roomOk    = ({1'b0, cnt} + (AW+1)'(8)) < freeSpace;

  assign bytePos = wrOffset + AW'(4) + cnt;
  assign dataPos = cfgWrap ? bytePos : (bytePos & mask);
  assign nextOff = (wrOffset + cnt + AW'(7)) & ~AW'(3) & mask;

  always_comb begin
    memWe   = strb.wrHdr | strb.wrByte;
    memAddr = dataPos[AW-1:2];
    memBe   = 4'b0001 << dataPos[1:0];
    memData = {4{rxData}};
    if (strb.wrHdr) begin
      memAddr = wrOffset[AW-1:2];
      memBe   = 4'hF;
      memData = {cnt[15:0], hdrStatus};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      wrOffset <= '0;
    end else begin
      if (strb.cntClr)      cnt <= '0;
      else if (strb.wrByte) cnt <= cnt + 1'b1;
      if (strb.wrHdr) wrOffset <= nextOff;
    end
  end
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int ERR_W  = 5,
  parameter int MT_W   = 3,
  parameter int MISS_W = 24
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic              rxLast,
  input  logic [ERR_W-1:0]  rxErr,
  input  logic [MT_W-1:0]   rxMatch,
  input  logic              roomOk,
  input  logic [7:0]        irqClr,
  output rxStrobe_t         strb,
  output logic [15:0]       hdrStatus,
  output logic [7:0]        irqStat,
  output logic [MISS_W-1:0] missedCnt
);
  localparam int PAD_W = 16 - MT_W - ERR_W - 1;

  logic hdrPend, dropping, byteIn, ovfNow, fifoNow;
  logic okB, errB, ovfB, fifoB;

  assign byteIn      = rxValid & ~hdrPend & ~dropping;
  assign ovfNow      = byteIn & ~roomOk;
  assign fifoNow     = rxValid & hdrPend;
  assign strb.wrByte = byteIn & roomOk;
  assign strb.wrHdr  = hdrPend;
  assign strb.cntClr = hdrPend | ovfNow;

  assign irqStat = {1'b0, fifoB, 1'b0, ovfB, 2'b00, errB, okB};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrPend   <= 1'b0;
      dropping  <= 1'b0;
      hdrStatus <= '0;
      okB <= 1'b0; errB <= 1'b0; ovfB <= 1'b0; fifoB <= 1'b0;
      missedCnt <= '0;
    end else begin
      hdrPend <= strb.wrByte & rxLast;
      if (strb.wrByte & rxLast)
        hdrStatus <= {rxMatch, PAD_W'(0), rxErr, ~|rxErr};
      if ((ovfNow | fifoNow) & ~rxLast) dropping <= 1'b1;
      else if (dropping & rxValid & rxLast) dropping <= 1'b0;
      okB   <= (okB   & ~irqClr[0]) | (hdrPend &  hdrStatus[0]);
      errB  <= (errB  & ~irqClr[1]) | (hdrPend & ~hdrStatus[0]);
      ovfB  <= (ovfB  & ~irqClr[4]) | ovfNow;
      fifoB <= (fifoB & ~irqClr[6]) | fifoNow;
      if (ovfNow) missedCnt <= missedCnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int BASE_BITS = 13,
  parameter int MAX_IDX   = 2,
  parameter int IDX_W     = 2,
  parameter int MISS_W    = 24,
  parameter int AW        = BASE_BITS + MAX_IDX + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  input  logic [4:0]        rxErr,
  input  logic [2:0]        rxMatch,
  input  logic [IDX_W-1:0]  cfgSizeIdx,
  input  logic              cfgWrap,
  input  logic [AW-1:0]     hostRdPtr,
  input  logic [7:0]        irqClr,
  output logic              memWe,
  output logic [AW-3:0]     memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memData,
  output logic [AW-1:0]     wrOffset,
  output logic              bufEmpty,
  output logic [7:0]        irqStat,
  output logic [MISS_W-1:0] missedCnt
);
  rxStrobe_t   strb;
  logic        roomOk;
  logic [15:0] hdrStatus;

  rx_ring_ctrl #(.ERR_W(5), .MT_W(3), .MISS_W(MISS_W)) ctrl_i (
    .clk, .rstN, .rxValid, .rxLast, .rxErr, .rxMatch, .roomOk, .irqClr,
    .strb, .hdrStatus, .irqStat, .missedCnt
  );

  rx_ring_dp #(.BASE_BITS(BASE_BITS), .IDX_W(IDX_W), .MAX_IDX(MAX_IDX), .AW(AW)) dp_i (
    .clk, .rstN, .strb, .cfgSizeIdx, .cfgWrap, .hostRdPtr, .rxData, .hdrStatus,
    .roomOk, .wrOffset, .bufEmpty, .memWe, .memAddr, .memBe, .memData
  );
endmodule

// File: rtl/rx_ring_chk.sv
module rx_ring_chk #(
  parameter int AW     = 16,
  parameter int MISS_W = 24
)(
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic              memWe,
  input logic [3:0]        memBe,
  input logic [AW-1:0]     wrOffset,
  input logic [7:0]        irqStat,
  input logic [MISS_W-1:0] missedCnt
);
  p_offset_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrOffset[1:0] == 2'b00);

  p_one_lane_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memBe != 4'hF) |-> $countones(memBe) == 1);

  p_byte_from_input_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memBe != 4'hF) |-> rxValid);

  p_hdr_advances_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memBe == 4'hF) |=> wrOffset != $past(wrOffset));

  p_ok_after_hdr_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStat[0]) |-> $past(memWe && memBe == 4'hF));

  p_missed_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    (missedCnt != $past(missedCnt)) |-> irqStat[4]);
endmodule

bind rx_ring_writer rx_ring_chk #(.AW(AW), .MISS_W(MISS_W)) chk_i (.*);

// File: tb/rx_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rx_ring_writer_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic rxValid = 0, rxLast = 0, cfgWrap = 0;
  logic [7:0] rxData = 0, irqClr = 0;
  logic [4:0] rxErr = 0;
  logic [2:0] rxMatch = 0;
  logic [1:0] cfgSizeIdx = 0;
  logic [15:0] hostRdPtr = 16'hFFF0;
  logic memWe, bufEmpty;
  logic [13:0] memAddr;
  logic [3:0] memBe;
  logic [31:0] memData;
  logic [15:0] wrOffset;
  logic [7:0] irqStat;
  logic [23:0] missedCnt;

  always #4 clk = ~clk;

  rx_ring_writer dut_i (.*);

  int checks = 0, failures = 0;
  int expWr = 0, expMissed = 0;
  logic [7:0] expIrq = 0;

  typedef struct packed { logic [15:0] len; logic [4:0] err; logic [2:0] mt; } vec_t;
  localparam vec_t VECS [8] = '{
    '{16'd1500, 5'h00, 3'd1}, '{16'd61,   5'h00, 3'd2},
    '{16'd1514, 5'h02, 3'd4}, '{16'd1203, 5'h00, 3'd2},
    '{16'd64,   5'h08, 3'd1}, '{16'd1499, 5'h00, 3'd2},
    '{16'd1500, 5'h00, 3'd0}, '{16'd1000, 5'h00, 3'd4}};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic int ringMask();
    return (8192 << ((cfgSizeIdx > 2) ? 2 : cfgSizeIdx)) - 1;
  endfunction

  // drive one frame; tailLen>0 pushes a late frame into the header cycle
  task automatic sendFrame(int len, logic [4:0] err, logic [2:0] mt, int seed,
                           logic [7:0] clr, int tailLen);
    int mask = ringMask();
    int cnt = 0;
    bit drop = 0;
    logic [7:0] setBits = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxValid = 1; rxData = 8'(i + seed); rxLast = (i == len - 1);
      rxErr = err; rxMatch = mt;
      #1;
      if (!drop) begin
        int rdOff = (int'(hostRdPtr) + 16) & mask;
        int gap   = (rdOff - expWr) & mask;
        int fr    = (gap == 0) ? mask + 1 : gap;
        if (cnt + 8 < fr) begin
          int pos = expWr + 4 + cnt;
          if (!cfgWrap) pos &= mask;
          chk("R3 byte", {memWe, memAddr, memBe, memData[7:0]},
              {1'b1, 14'(pos >> 2), 4'(1 << (pos & 3)), 8'(i + seed)});
          cnt++;
        end else begin
          chk("R7 refuse", 64'(memWe), 64'(0));
          drop = 1; expMissed++; expIrq |= 8'h10;
        end
      end else chk("R7 dropped", 64'(memWe), 64'(0));
    end
    @(negedge clk);
    rxValid = (tailLen > 0); rxLast = (tailLen == 1); rxData = 8'hA5; irqClr = clr;
    #1;
    if (!drop) begin
      chk("R2 header", {memWe, memAddr, memBe, memData},
          {1'b1, 14'(expWr >> 2), 4'hF, 16'(len), mt, 7'd0, err, (err == 0)});
      expWr = (expWr + len + 7) & ~3 & mask;
      setBits = (err == 0) ? 8'h01 : 8'h02;
    end else chk("R7 no header", 64'(memWe), 64'(0));
    if (tailLen > 0) setBits |= 8'h40;
    expIrq = (expIrq & ~clr) | setBits;
    for (int t = 1; t < tailLen; t++) begin
      @(negedge clk);
      irqClr = 0; rxValid = 1; rxLast = (t == tailLen - 1); rxData = 8'(t);
      #1 chk("R9 late frame discarded", 64'(memWe), 64'(0));
    end
    @(negedge clk);
    rxValid = 0; rxLast = 0; irqClr = 0;
    #1;
    chk("R4 offset", 64'(wrOffset), 64'(expWr));
    chk("R8 status bits", 64'(irqStat), 64'(expIrq));
    chk("R7 missed count", 64'(missedCnt), 64'(expMissed));
  endtask

  task automatic consume(string req);
    chk({req, " not empty"}, 64'(bufEmpty), 64'(0));
    hostRdPtr = 16'(expWr - 16);
    #1 chk({req, " empty"}, 64'(bufEmpty), 64'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R11 offset", 64'(wrOffset), 64'(0));
    chk("R11 status", 64'(irqStat), 64'(0));
    chk("R11 missed", 64'(missedCnt), 64'(0));
    chk("R11 no write", 64'(memWe), 64'(0));
    chk("R5 empty via ptr-16", 64'(bufEmpty), 64'(1));
    @(negedge clk) rstN = 1;

    // vector table: mode 0 wraps at end (R6), mode 1 runs past end, then 16 KiB ring (R1)
    for (int round = 0; round < 3; round++) begin
      cfgWrap    = (round == 1);
      cfgSizeIdx = (round == 2) ? 2'd1 : 2'd0;
      foreach (VECS[k]) begin
        sendFrame(int'(VECS[k].len), VECS[k].err, VECS[k].mt, k * 7 + round, 8'h00, 0);
        consume("R5");
      end
      chk(round == 2 ? "R1 ring size" : "R6 wrap mode", 64'(wrOffset), 64'(expWr));
    end

    // overflow: never consume until frames are refused (R7)
    cfgWrap = 0;
    for (int k = 0; k < 12; k++) sendFrame(1500, 5'h00, 3'd2, k, 8'h00, 0);
    chk("R7 overflow seen", 64'(missedCnt != 0), 64'(1));
    chk("R7 overflow bit", 64'(irqStat[4]), 64'(1));
    consume("R5");

    // write-one-to-clear (R10)
    @(negedge clk) irqClr = 8'hFF;
    @(negedge clk) irqClr = 8'h00;
    #1 chk("R10 clear all", 64'(irqStat), 64'(0));
    expIrq = 0;

    // error frame sets bit1, then ok frame whose header cycle also clears bits 0 and 1 (R10)
    sendFrame(100, 5'h04, 3'd1, 3, 8'h00, 0);
    consume("R5");
    sendFrame(77, 5'h00, 3'd2, 9, 8'h03, 0);
    chk("R10 set wins over clear", 64'(irqStat[1:0]), 64'(2'b01));
    consume("R5");

    // byte during header cycle (R9)
    sendFrame(90, 5'h00, 3'd1, 1, 8'h00, 20);
    chk("R9 lost byte bit", 64'(irqStat[6]), 64'(1));
    consume("R5");
    sendFrame(60, 5'h00, 3'd4, 5, 8'h00, 1);
    consume("R5");
    sendFrame(70, 5'h00, 3'd4, 2, 8'h00, 0);
    consume("R5");

    // size index 3 behaves as 2 (R1)
    cfgSizeIdx = 2'd3;
    sendFrame(200, 5'h00, 3'd1, 4, 8'h00, 0);
    consume("R1");

    report();
  end
endmodule